// File: doc/BRIEF.md
# Self-Timed Word Programming Sequencer

This block carries out the programming phase of a word-organised serial memory. A serial front end hands it a command kind (one word, a page of up to four words, or one word copied to every location), a start address and each data word as its last bit is clocked in. The sequencer collects those words and watches chip select. When chip select drops right after a complete word, and the write is allowed, it runs a program cycle whose length is a fixed number of system clocks. During that cycle it raises `busy` and drives the array write port, one location per clock.

The serial clock has no effect on the cycle once it has begun. Page addressing keeps the upper address bits fixed and steps only the two low bits, so a page write wraps inside its four-word page. A write is dropped without touching the array when writes are not enabled, when any targeted location sits in the guarded region, or when an extra serial edge follows the last word the command can take. The array itself, blank at all ones, lives outside the block.

Top module: `prog_seq`

## Requirements
- R1: After reset `busy` and `arr_we` are 0.
- R2: A single-word command (`cmd_kind` = 2'b01) followed by one word and a chip-select fall writes that word to the start address exactly once. `busy` rises on the clock edge that samples `cs` low and stays high for exactly PROG_CYCLES cycles.
- R3: A page command (`cmd_kind` = 2'b10) with N complete words (1 to 4) writes word k to the address whose bits [6:2] equal those of the start address and whose bits [1:0] equal (start[1:0] + k) mod 4. Exactly N writes occur.
- R4: In a page write, serial edges that form an incomplete later word are discarded. Only the complete words are programmed.
- R5: A write-all command (`cmd_kind` = 2'b11) with one word writes that word to all 128 locations in one cycle.
- R6: With no complete word received, a chip-select fall starts no cycle and writes nothing.
- R7: A serial edge (`ser_edge`) that arrives after the last word a command can take cancels that command: 1 word for single and write-all, 4 words for a page. The chip-select fall then starts no cycle.
- R8: With `wr_permit` low, no cycle starts and nothing is written.
- R9: With `guard_en` high, a single or page write starts no cycle if any targeted address is at or above `guard_base`. A write-all starts no cycle while `guard_en` is high.
- R10: While `busy` is high, new commands, words and chip-select falls are ignored and cause no extra writes.
- R11: The cycle length and the writes do not depend on `ser_edge` activity during the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip-select level from the serial pins |
| ser_edge | input | 1 | One-cycle pulse per rising serial clock edge |
| cmd_start | input | 1 | Pulse: a write command was decoded |
| cmd_kind | input | 2 | 01 single, 10 page, 11 write-all, 00 ignored |
| cmd_addr | input | 7 | Start address of the command |
| word_valid | input | 1 | Pulse: a complete data word was shifted in (coincides with its last serial edge) |
| word_data | input | 16 | The completed data word |
| wr_permit | input | 1 | Writes are enabled |
| guard_en | input | 1 | Write guard region is active |
| guard_base | input | 7 | Lowest guarded address |
| busy | output | 1 | Program cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 7 | Array write address |
| arr_wdata | output | 16 | Array write data |

## Verification
Page writes are swept over every start offset inside a page and every word count from one to four. A wrong wrap, an off-by-one count or a carry into the upper bits would each put data in a different cell of the blank array. Single and write-all runs separate one-cell from whole-array programming. Runs with trailing serial edges tell a discarded partial word apart from a cancelled command. A guard base swept across one page, together with writes disabled, shows that blocking depends on every targeted address. Serial edges and a second command during each cycle show that the cycle length and the write count stay fixed.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [1:0] {
    K_NONE   = 2'b00,
    K_SINGLE = 2'b01,
    K_PAGE   = 2'b10,
    K_ALL    = 2'b11
  } wr_kind_t;
endpackage

// File: rtl/prog_gather.sv
module prog_gather
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 16,
  parameter int PAGE_WORDS = 4,
  localparam int CW        = $clog2(PAGE_WORDS + 1),
  localparam int PAW       = $clog2(PAGE_WORDS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               busy,
  input  logic                               cs_fall,
  input  logic                               ser_edge,
  input  logic                               cmd_start,
  input  wr_kind_t                           cmd_kind,
  input  logic [ADDR_W-1:0]                  cmd_addr,
  input  logic                               word_valid,
  input  logic [DATA_W-1:0]                  word_data,
  output wr_kind_t                           kind,
  output logic [ADDR_W-1:0]                  base,
  output logic [CW-1:0]                      count,
  output logic [PAGE_WORDS-1:0][DATA_W-1:0]  slots,
  output logic                               fire
);
  logic              open_q, cancel_q;
  wr_kind_t          kind_q;
  logic [ADDR_W-1:0] base_q;
  logic [CW-1:0]     cnt_q, limit;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] slots_q;
  logic              full;

  assign limit = (kind_q == K_PAGE) ? CW'(PAGE_WORDS) : CW'(1);
  assign full  = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q   <= 1'b0;
      cancel_q <= 1'b0;
      kind_q   <= K_NONE;
      base_q   <= '0;
      cnt_q    <= '0;
      slots_q  <= '0;
    end else if (!busy) begin
      if (cs_fall) begin
        open_q <= 1'b0;
      end else if (cmd_start && cmd_kind != K_NONE) begin
        open_q   <= 1'b1;
        cancel_q <= 1'b0;
        kind_q   <= cmd_kind;
        base_q   <= cmd_addr;
        cnt_q    <= '0;
      end else if (open_q) begin
        if (word_valid && !full) begin
          slots_q[cnt_q[PAW-1:0]] <= word_data;
          cnt_q <= cnt_q + CW'(1);
        end else if (ser_edge && full) begin
          cancel_q <= 1'b1;
        end
      end
    end
  end

  assign fire  = open_q && cs_fall && (cnt_q != '0) && !cancel_q;
  assign kind  = kind_q;
  assign base  = base_q;
  assign count = cnt_q;
  assign slots = slots_q;

  // R4: never more words held than the command can take
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    open_q |-> (cnt_q <= limit));
endmodule

// File: rtl/prog_guard.sv
module prog_guard
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int PAGE_WORDS = 4,
  localparam int CW        = $clog2(PAGE_WORDS + 1),
  localparam int PAW       = $clog2(PAGE_WORDS)
) (
  input  wr_kind_t          kind,
  input  logic [ADDR_W-1:0] base,
  input  logic [CW-1:0]     count,
  input  logic              wr_permit,
  input  logic              guard_en,
  input  logic [ADDR_W-1:0] guard_base,
  output logic              permit
);
  logic [PAGE_WORDS-1:0] hit;

  for (genvar i = 0; i < PAGE_WORDS; i++) begin : g_tgt
    logic [ADDR_W-1:0] tgt;
    assign tgt    = {base[ADDR_W-1:PAW], base[PAW-1:0] + PAW'(i)};
    assign hit[i] = (CW'(i) < count) && (tgt >= guard_base);
  end

  always_comb begin
    if (kind == K_ALL) permit = wr_permit && !guard_en;
    else               permit = wr_permit && !(guard_en && (|hit));
  end
endmodule

// File: rtl/prog_engine.sv
module prog_engine
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PAGE_WORDS  = 4,
  parameter int PROG_CYCLES = 500,
  localparam int CW         = $clog2(PAGE_WORDS + 1),
  localparam int PAW        = $clog2(PAGE_WORDS),
  localparam int DEPTH      = 1 << ADDR_W,
  localparam int TW         = $clog2(PROG_CYCLES) + 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              go,
  input  wr_kind_t                          kind,
  input  logic [ADDR_W-1:0]                 base,
  input  logic [CW-1:0]                     count,
  input  logic [PAGE_WORDS-1:0][DATA_W-1:0] slots,
  output logic                              busy,
  output logic                              arr_we,
  output logic [ADDR_W-1:0]                 arr_addr,
  output logic [DATA_W-1:0]                 arr_wdata
);
  logic [TW-1:0]     tcnt_q, nwr_q;
  logic [ADDR_W-1:0] wa;
  logic [DATA_W-1:0] wd;

  always_comb begin
    if (kind == K_ALL) begin
      wa = tcnt_q[ADDR_W-1:0];
      wd = slots[0];
    end else begin
      wa = {base[ADDR_W-1:PAW], base[PAW-1:0] + tcnt_q[PAW-1:0]};
      wd = slots[tcnt_q[PAW-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tcnt_q    <= '0;
      nwr_q     <= '0;
      arr_we    <= 1'b0;
      arr_addr  <= '0;
      arr_wdata <= '0;
    end else begin
      arr_we <= 1'b0;
      if (!busy) begin
        if (go) begin
          busy   <= 1'b1;
          tcnt_q <= '0;
          nwr_q  <= (kind == K_ALL) ? TW'(DEPTH) : TW'(count);
        end
      end else begin
        if (tcnt_q < nwr_q) begin
          arr_we    <= 1'b1;
          arr_addr  <= wa;
          arr_wdata <= wd;
        end
        if (tcnt_q == TW'(PROG_CYCLES - 1)) busy <= 1'b0;
        tcnt_q <= tcnt_q + TW'(1);
      end
    end
  end

  // R3: page writes never leave the page of the start address
  a_r3_page_wrap: assert property (@(posedge clk) disable iff (rst)
    (arr_we && kind == K_PAGE) |-> (arr_addr[ADDR_W-1:PAW] == base[ADDR_W-1:PAW]));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PAGE_WORDS  = 4,
  parameter int PROG_CYCLES = 500,
  localparam int CW         = $clog2(PAGE_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              ser_edge,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              word_valid,
  input  logic [DATA_W-1:0] word_data,
  input  logic              wr_permit,
  input  logic              guard_en,
  input  logic [ADDR_W-1:0] guard_base,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  logic              cs_q, cs_fall, fire, permit, go;
  wr_kind_t          kind;
  logic [ADDR_W-1:0] base;
  logic [CW-1:0]     count;
  logic [PAGE_WORDS-1:0][DATA_W-1:0] slots;

  always_ff @(posedge clk) begin
    if (rst) cs_q <= 1'b0;
    else     cs_q <= cs;
  end
  assign cs_fall = cs_q && !cs;
  assign go      = fire && permit && !busy;

  prog_gather #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS)) u_gather (
    .clk(clk), .rst(rst), .busy(busy), .cs_fall(cs_fall), .ser_edge(ser_edge),
    .cmd_start(cmd_start), .cmd_kind(wr_kind_t'(cmd_kind)), .cmd_addr(cmd_addr),
    .word_valid(word_valid), .word_data(word_data),
    .kind(kind), .base(base), .count(count), .slots(slots), .fire(fire)
  );

  prog_guard #(.ADDR_W(ADDR_W), .PAGE_WORDS(PAGE_WORDS)) u_guard (
    .kind(kind), .base(base), .count(count), .wr_permit(wr_permit),
    .guard_en(guard_en), .guard_base(guard_base), .permit(permit)
  );

  prog_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_WORDS(PAGE_WORDS),
                .PROG_CYCLES(PROG_CYCLES)) u_engine (
    .clk(clk), .rst(rst), .go(go), .kind(kind), .base(base), .count(count),
    .slots(slots), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  // R6: a cycle begins only on a sampled chip-select fall
  a_r6_start_on_fall: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_fall));
  // R8 / R9: a cycle begins only when the guard allowed it
  a_r9_start_permitted: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(permit));
  // R10: array strobes only inside a program cycle
  a_r10_we_in_cycle: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> $past(busy));
endmodule

// File: tb/prog_seq_tb.sv
module prog_seq_tb;
  localparam int CLK_P = 10;
  localparam int PROG  = 160;
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst = 1, cs = 0, ser_edge = 0, cmd_start = 0, word_valid = 0;
  logic [1:0] cmd_kind = 0;
  logic [AW-1:0] cmd_addr = 0, guard_base = 0;
  logic [15:0] word_data = 0;
  logic wr_permit = 0, guard_en = 0;
  logic busy, arr_we;
  logic [AW-1:0] arr_addr;
  logic [15:0] arr_wdata;

  int total = 0, fails = 0, nwrites = 0, seed = 1;
  bit done = 0;
  logic [15:0] mem [DEPTH];
  logic [15:0] model [DEPTH];

  always #(CLK_P/2) clk = ~clk;

  prog_seq #(.PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .ser_edge(ser_edge), .cmd_start(cmd_start),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .word_valid(word_valid),
    .word_data(word_data), .wr_permit(wr_permit), .guard_en(guard_en),
    .guard_base(guard_base), .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  always @(posedge clk) if (arr_we) begin
    mem[arr_addr] <= arr_wdata;
    nwrites = nwrites + 1;
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic edge_only;
    ser_edge = 1; @(negedge clk); ser_edge = 0; @(negedge clk);
  endtask

  // kind: 1 single, 2 page, 3 all. stray: serial edges after the words.
  task automatic do_write(logic [1:0] kind, logic [AW-1:0] addr, int n, int stray,
                          bit poke, string req);
    int lim, busy_n, bad, first;
    bit prot, goes;
    logic [15:0] d [4];
    lim = (kind == 2) ? 4 : 1;
    prot = 0;
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] a;
      d[k] = 16'((seed * 40503 + k * 4099) ^ 16'h5A3C);
      a = {addr[AW-1:2], 2'(addr[1:0] + 2'(k))};
      if (kind != 3 && guard_en && a >= guard_base) prot = 1;
    end
    if (kind == 3 && guard_en) prot = 1;
    goes = wr_permit && n > 0 && !(stray > 0 && n == lim) && !prot;
    if (goes) begin
      if (kind == 3) for (int i = 0; i < DEPTH; i++) model[i] = d[0];
      else for (int k = 0; k < n; k++)
        model[{addr[AW-1:2], 2'(addr[1:0] + 2'(k))}] = d[k];
    end
    seed++;
    @(negedge clk); cs = 1;
    @(negedge clk); cmd_start = 1; cmd_kind = kind; cmd_addr = addr;
    @(negedge clk); cmd_start = 0;
    for (int k = 0; k < n; k++) begin
      edge_only(); edge_only();
      ser_edge = 1; word_valid = 1; word_data = d[k];
      @(negedge clk); ser_edge = 0; word_valid = 0;
    end
    repeat (stray) edge_only();
    nwrites = 0;
    cs = 0;
    busy_n = 0;
    for (int i = 0; i < PROG + 10; i++) begin
      @(negedge clk);
      if (busy) busy_n++;
      ser_edge = i[0];
      if (poke) begin
        if (i == 3) begin cs = 1; cmd_start = 1; cmd_kind = 2; cmd_addr = 7'd0; end
        if (i == 4) begin cmd_start = 0; word_valid = 1; word_data = 16'h0BAD; end
        if (i == 5) begin word_valid = 0; cs = 0; end
      end
    end
    ser_edge = 0;
    @(negedge clk);
    check(busy_n == (goes ? PROG : 0), {req, " busy length"}, busy_n, goes ? PROG : 0);
    check(nwrites == (goes ? (kind == 3 ? DEPTH : n) : 0), {req, " write count"},
          nwrites, goes ? (kind == 3 ? DEPTH : n) : 0);
    bad = 0; first = -1;
    for (int i = 0; i < DEPTH; i++) if (mem[i] !== model[i]) begin
      bad++; if (first < 0) first = i;
    end
    check(bad == 0, {req, " array content"}, first < 0 ? 0 : int'(mem[first]),
          first < 0 ? 0 : int'(model[first]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin mem[i] = 16'hFFFF; model[i] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    check(busy == 0, "R1 busy after reset", int'(busy), 0);
    check(arr_we == 0, "R1 we after reset", int'(arr_we), 0);

    wr_permit = 1;
    do_write(2'd1, 7'd5, 1, 0, 0, "R2 single");
    do_write(2'd1, 7'd127, 1, 0, 0, "R2 single top");
    for (int off = 0; off < 4; off++)
      for (int n = 1; n <= 4; n++)
        do_write(2'd2, 7'(32 + 4 * n + off), n, 0, 0, "R3 page sweep");
    do_write(2'd2, 7'd70, 2, 5, 0, "R4 partial word");
    do_write(2'd2, 7'd81, 3, 1, 0, "R4 partial edge");
    do_write(2'd2, 7'd90, 4, 1, 0, "R7 page cancel");
    do_write(2'd1, 7'd95, 1, 1, 0, "R7 single cancel");
    do_write(2'd3, 7'd0, 1, 2, 0, "R7 all cancel");
    do_write(2'd1, 7'd99, 0, 0, 0, "R6 no word");
    do_write(2'd2, 7'd99, 0, 3, 0, "R6 page no word");
    wr_permit = 0;
    do_write(2'd1, 7'd100, 1, 0, 0, "R8 disabled");
    do_write(2'd2, 7'd100, 4, 0, 0, "R8 page disabled");
    wr_permit = 1;
    guard_en = 1;
    for (int g = 60; g <= 64; g++) begin
      guard_base = 7'(g);
      do_write(2'd2, 7'd62, 4, 0, 0, "R9 guard sweep");
    end
    guard_base = 7'd64;
    do_write(2'd1, 7'd63, 1, 0, 0, "R9 below guard");
    do_write(2'd1, 7'd64, 1, 0, 0, "R9 at guard");
    do_write(2'd3, 7'd0, 1, 0, 0, "R9 all guarded");
    guard_en = 0;
    do_write(2'd1, 7'd12, 1, 0, 1, "R10 ignore while busy");
    do_write(2'd3, 7'd0, 1, 0, 0, "R5 write all");
    do_write(2'd2, 7'd126, 3, 0, 1, "R11 page during edges");
    done = 1;
    report();
    $finish;
  end
endmodule